// File: doc/BRIEF.md
# Four-Voice Mixer with PWM DAC

This block adds four signed voice samples into one signed mix. It turns the mix into an unsigned duty value by flipping the sign bit, which gives offset binary so that silence maps to half duty. A single output bit carries pulse-width modulation whose average level follows the mix. An external low-pass filter and amplifier turn that bit into audio. A one-clock strobe marks the first cycle of every PWM period, for test and for synchronisation.

A free-running ramp counter sets the PWM period at 2^DATA_W clocks. With DATA_W = 10 and a 100 MHz clock, the carrier is about 97.6 kHz, well above the audio band. A wider counter would pull the carrier down into the audible range: 13 bits would give about 12.2 kHz. The duty value is taken only when the ramp wraps to zero, so each period uses exactly one duty value.

The output comes from a two-state machine. PH_MARK drives the bit high and PH_SPACE drives it low. On every clock the machine goes to PH_MARK if the next ramp value is below the next duty value, and to PH_SPACE otherwise. The two transitions are SPACE to MARK, which happens at the start of a period with a non-zero duty, and MARK to SPACE, which happens when the ramp reaches the duty value. Reset places the machine in PH_SPACE.

Top module: `four_voice_pwm_dac`

## Requirements
- R1: The duty value taken at a wrap equals the two's-complement sum of the four voices with its most significant bit inverted. Voice i occupies bits [i*DATA_W +: DATA_W] of the voice bus. An all-zero mix gives duty 2^(DATA_W-1), and a mix of -1 gives 2^(DATA_W-1)-1.
- R2: The ramp counter advances by one on every clock and wraps from 2^DATA_W-1 to 0. Consecutive strobes are exactly 2^DATA_W clocks apart, and the strobe is never high for two cycles in a row.
- R3: Every voice sample stays within -2^(DATA_W-3) to 2^(DATA_W-3)-1, so the four-voice sum never overflows DATA_W bits. A sample outside this range is flagged.
- R4: In every cycle after the first cycle out of reset, the PWM bit is high exactly when the ramp value is below the latched duty. A period with duty d therefore holds the bit high for d cycles.
- R5: Voice changes in the middle of a period have no effect on that period's high time. They take effect from the next period.
- R6: While reset is asserted, the ramp is 0, the latched duty is 2^(DATA_W-1), and both the PWM bit and the strobe are low. The PWM bit is also low in the first cycle after reset is released.
- R7: A duty of 0 keeps the PWM bit low for the whole period.
- R8: The strobe is high in the cycle in which the ramp is 0 after a wrap, and in no other cycle. In that cycle the PWM bit is high exactly when the new duty is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| voices_i | input | VOICES*DATA_W | Packed signed voice samples, voice i at bits [i*DATA_W +: DATA_W] |
| pwm_o | output | 1 | PWM bit |
| period_start_o | output | 1 | One-clock strobe in the first cycle of each period |

## Verification
The bench builds the block with DATA_W = 6 and VOICES = 4. This shrinks the period to 64 clocks and the per-voice range to -8..7, so many whole periods fit in a short run. It also puts the extremes within reach: the all-negative mix that gives duty 0, the largest legal mix, and the -1 mix that sits just below the midpoint. A behavioural model of ramp, latched duty and strobe is compared with both outputs on every clock. Whole-period high counts tie each voice pattern to its expected duty, including a voice change made in the middle of a period.

// File: rtl/mix_pkg.sv
package mix_pkg;

    // Output phase of the PWM machine
    typedef enum logic {
        PH_SPACE = 1'b0,
        PH_MARK  = 1'b1
    } pwm_phase_e;

    localparam int unsigned MIX_DATA_W_DEF = 10;
    localparam int unsigned MIX_VOICES_DEF = 4;

endpackage

// File: rtl/voice_summer.sv
module voice_summer #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned VOICES = 4
) (
    input  logic [VOICES*DATA_W-1:0] voices_i,
    output logic [DATA_W-1:0]        duty_o
);

    logic signed [DATA_W-1:0] partial [VOICES+1];

    assign partial[0] = '0;

    generate
        for (genvar gi = 0; gi < VOICES; gi++) begin : g_acc
            assign partial[gi+1] = partial[gi] + $signed(voices_i[gi*DATA_W +: DATA_W]);
        end
    endgenerate

    // offset binary: flip the sign bit
    assign duty_o = {~partial[VOICES][DATA_W-1], partial[VOICES][DATA_W-2:0]};

endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             wrap_o,
    output logic             start_o
);

    localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             start_q;

    assign cnt_nxt_o = cnt_q + STEP;
    assign wrap_o    = (cnt_q == {CNT_W{1'b1}});
    assign cnt_o     = cnt_q;
    assign start_o   = start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt_o;
            start_q <= wrap_o;
        end
    end

endmodule

// File: rtl/duty_phase_fsm.sv
module duty_phase_fsm
    import mix_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_nxt_i,
    input  logic              wrap_i,
    input  logic [DATA_W-1:0] duty_new_i,
    output logic [DATA_W-1:0] duty_o,
    output logic              pwm_o
);

    localparam logic [DATA_W-1:0] MIDPOINT = {1'b1, {(DATA_W-1){1'b0}}};

    pwm_phase_e        state_q, state_d;
    logic [DATA_W-1:0] duty_q, duty_d;

    always_comb begin
        duty_d  = wrap_i ? duty_new_i : duty_q;
        state_d = (cnt_nxt_i < duty_d) ? PH_MARK : PH_SPACE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_SPACE;
            duty_q  <= MIDPOINT;
        end else begin
            state_q <= state_d;
            duty_q  <= duty_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PH_MARK:  pwm_o = 1'b1;
            PH_SPACE: pwm_o = 1'b0;
            default:  pwm_o = 1'b0;
        endcase
    end

    assign duty_o = duty_q;

endmodule

// File: rtl/four_voice_pwm_dac.sv
module four_voice_pwm_dac
    import mix_pkg::*;
#(
    parameter int unsigned DATA_W = MIX_DATA_W_DEF,
    parameter int unsigned VOICES = MIX_VOICES_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VOICES*DATA_W-1:0] voices_i,
    output logic                     pwm_o,
    output logic                     period_start_o
);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_nxt;
    logic              wrap;
    logic [DATA_W-1:0] duty_new;
    logic [DATA_W-1:0] duty_q;

    voice_summer #(.DATA_W(DATA_W), .VOICES(VOICES)) u_sum (
        .voices_i (voices_i),
        .duty_o   (duty_new)
    );

    ramp_counter #(.CNT_W(DATA_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap),
        .start_o   (period_start_o)
    );

    duty_phase_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_nxt_i  (cnt_nxt),
        .wrap_i     (wrap),
        .duty_new_i (duty_new),
        .duty_o     (duty_q),
        .pwm_o      (pwm_o)
    );

endmodule

// File: rtl/mix_pwm_checker.sv
module mix_pwm_checker #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned VOICES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [VOICES*DATA_W-1:0] voices_i,
    input logic [DATA_W-1:0]        cnt_q,
    input logic [DATA_W-1:0]        duty_q,
    input logic                     pwm_o,
    input logic                     period_start_o
);

    localparam int LIM = 2 ** (DATA_W - 1 - $clog2(VOICES));

    generate
        for (genvar gv = 0; gv < VOICES; gv++) begin : g_rng
            // R3: each voice inside its headroom range
            p_voice_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (int'($signed(voices_i[gv*DATA_W +: DATA_W])) >= -LIM) &&
                (int'($signed(voices_i[gv*DATA_W +: DATA_W])) <= LIM - 1));
        end
    endgenerate

    // R2: strobe lasts a single cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |=> !period_start_o);

    // R8: strobe only with the ramp at zero
    p_strobe_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> (cnt_q == '0));

    // R5: latched duty moves only when the ramp has just wrapped
    p_duty_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_q) |-> (cnt_q == '0));

    // R4: output follows ramp against latched duty
    p_pwm_compare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pwm_o == (cnt_q < duty_q)));

endmodule

bind four_voice_pwm_dac mix_pwm_checker #(.DATA_W(DATA_W), .VOICES(VOICES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .voices_i       (voices_i),
    .cnt_q          (cnt_q),
    .duty_q         (duty_q),
    .pwm_o          (pwm_o),
    .period_start_o (period_start_o)
);

// File: tb/four_voice_pwm_dac_bench.sv
`timescale 1ns/1ps
module four_voice_pwm_dac_bench;

    localparam int W    = 6;
    localparam int NV   = 4;
    localparam int P    = 1 << W;
    localparam int HALF = P / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NV*W-1:0] voices = '0;
    logic            pwm;
    logic            strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int vin [NV];

    always #2.5 clk = ~clk;

    four_voice_pwm_dac #(.DATA_W(W), .VOICES(NV)) u_four_voice_pwm_dac (
        .clk            (clk),
        .rst_n          (rst_n),
        .voices_i       (voices),
        .pwm_o          (pwm),
        .period_start_o (strobe)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_voices(int a, int b, int c, int d);
        vin[0] = a; vin[1] = b; vin[2] = c; vin[3] = d;
        for (int i = 0; i < NV; i++) voices[i*W +: W] = vin[i][W-1:0];
    endtask

    // behavioural reference: ramp, latched duty, strobe, output bit
    int m_cnt, m_duty, m_pwm, m_str;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_duty = HALF; m_pwm = 0; m_str = 0;
        end else begin
            int s;
            s = vin[0] + vin[1] + vin[2] + vin[3];
            if (m_cnt == P - 1) m_duty = s + HALF;
            m_str = (m_cnt == P - 1) ? 1 : 0;
            m_cnt = (m_cnt + 1) % P;
            m_pwm = (m_cnt < m_duty) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pwm == m_pwm[0], "R4 pwm against model", int'(pwm), m_pwm);
            check(strobe == m_str[0], "R8 strobe against model", int'(strobe), m_str);
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!strobe);
    endtask

    // called at the negedge of a strobe cycle; returns at the next one
    task automatic measure(output int highs, output int len);
        highs = 0; len = 0;
        do begin
            highs += int'(pwm);
            len++;
            @(negedge clk);
        end while (!strobe && len < 4 * P);
    endtask

    task automatic run_pattern(int a, int b, int c, int d, int exp, string tag);
        int h, l;
        set_voices(a, b, c, d);
        measure(h, l);
        measure(h, l);
        check(l == P, "R2 period length", l, P);
        check(h == exp, tag, h, exp);
    endtask

    initial begin
        int h, l;
        set_voices(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check(pwm == 1'b0, "R6 pwm low in reset", int'(pwm), 0);
        check(strobe == 1'b0, "R6 strobe low in reset", int'(strobe), 0);
        rst_n = 1'b1;
        check(pwm == 1'b0, "R6 pwm low after release", int'(pwm), 0);
        // first period after reset: midpoint duty, first cycle held low
        h = 0; l = 0;
        do begin h += int'(pwm); l++; @(negedge clk); end while (!strobe && l < 4 * P);
        check(l == P, "R2 first strobe delay", l, P);
        check(h == HALF - 1, "R6 midpoint duty in first period", h, HALF - 1);
        measure(h, l);
        check(l == P, "R2 period length", l, P);
        check(h == HALF, "R1 silence gives half duty", h, HALF);

        // R3: all stimulus stays inside the per-voice range, largest legal mix
        run_pattern(7, 7, 7, 7, 60, "R1 R3 largest mix duty");
        run_pattern(-8, -8, -8, -8, 0, "R7 zero duty stays low");
        run_pattern(7, -3, 5, -8, 33, "R1 mixed voices duty");
        run_pattern(-1, 0, 0, 0, HALF - 1, "R1 minus one below midpoint");
        run_pattern(2, 2, 2, 2, 40, "R1 positive mix duty");

        // R5: change voices in the middle of a period with duty 40
        h = 0; l = 0;
        repeat (20) begin h += int'(pwm); l++; @(negedge clk); end
        set_voices(-5, -5, -5, -5);
        while (!strobe && l < 4 * P) begin h += int'(pwm); l++; @(negedge clk); end
        check(h == 40, "R5 mid-period change ignored", h, 40);
        measure(h, l);
        check(h == 12, "R5 change applied next period", h, 12);

        set_voices(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule